// File: doc/BRIEF.md
# Multicart Outer Bank Translator

This block sits beside an inner bank controller of the common scanline-counter type in a three-game cartridge. It keeps a 3-bit outer block value, loaded by CPU writes that land in the $6000-$7FFF window, and uses it to widen the inner controller's raw 8 KiB program bank number and raw 1 KiB character bank number into final bank numbers for a 256 KiB program ROM and a 256 KiB character ROM.

The program mapping is not a plain concatenation. Program address bit 16 is a gated mix of two outer bits and bit 3 of the raw bank, so the outer value selects unequal windows: two 64 KiB blocks in the lower half and one 128 KiB block in the upper half. The character mapping simply places outer bit 2 above the low seven raw bits. Both translations are combinational. The window holds no RAM: reads there are claimed by the block and return zero, and writes there are kept away from the inner controller, while all other writes pass through to it.

Top module: `mc_outer_xlat`

## Requirements
- R1: A CPU write (`cpu_we`=1) to an address in $6000-$7FFF (address bits [15:13] = 3'b011), accepted per R2, loads the outer value Q from `cpu_wdata[2:0]`; data bits [7:3] are dropped. The new Q is visible at the outputs in the cycle after the write edge.
- R2: A write to the window is accepted only when `wram_en`=1 and `wram_wp`=0; in any other combination Q keeps its value.
- R3: Synchronous active-low reset sets Q to 0.
- R4: `prg_bank` = {Q2, A16, `raw_prg[2:0]`} with A16 = (Q1 AND Q0) OR (Q2 AND `raw_prg[3]`); raw bits above bit 3 are not used.
- R5: `chr_bank` = {Q2, `raw_chr[6:0]`}; `raw_chr[7]` is not used.
- R6: `rd_own` is 1 exactly when `cpu_rd`=1 and the address is in the window, and `rd_data` is then 0x00.
- R7: `inner_we` equals `cpu_we` for addresses outside the window and is 0 inside it; writes outside the window never change Q.
- R8: With raw program bank 0x0F the final bank is 7 for Q=0, 15 for Q=3 and 31 for Q=4; with raw character bank 5 the final bank is 5 when Q2=0 and 133 when Q2=1.
- R9: Both translations are combinational: a change of `raw_prg` or `raw_chr` appears on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| wram_en | input | 1 | Inner controller reports work-RAM enabled |
| wram_wp | input | 1 | Inner controller reports work-RAM write protected |
| raw_prg | input | 6 | Raw 8 KiB program bank from the inner controller |
| raw_chr | input | 8 | Raw 1 KiB character bank from the inner controller |
| prg_bank | output | 5 | Final 8 KiB program bank |
| chr_bank | output | 8 | Final 1 KiB character bank |
| rd_own | output | 1 | Block owns the current read |
| rd_data | output | 8 | Read data for an owned read |
| inner_we | output | 1 | Write strobe forwarded to the inner controller |

## Verification
The bench builds the block with its default widths: a 6-bit raw program bank and an 8-bit raw character bank, so the unused raw bits (bits 5:4 of the program bank, bit 7 of the character bank) are toggled and shown to have no effect. At these widths every one of the eight outer values can be swept against all 64 raw program banks and all 256 raw character banks, which reaches every cell of the A16 gating, including the upper-half windows where raw bit 3 matters. Write acceptance is driven through all four enable/protect combinations, at both window edges and just outside them.

// File: rtl/mc_outer_pkg.sv
// Package: shared widths and address decode for the outer bank translator.
// Assumes a 16-bit CPU address with the outer window at $6000-$7FFF.
package mc_outer_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int Q_W     = 3;
    localparam int WIN_MSB = ADDR_W - 1;
    localparam int WIN_LSB = 13;
    localparam int WIN_W   = WIN_MSB - WIN_LSB + 1;
    localparam logic [WIN_W-1:0] WIN_TAG = 3'b011;

    // Outer value split into its named bits.
    typedef struct packed {
        logic hi;   // Q2: selects upper half, enables raw bit 3
        logic mid;  // Q1
        logic lo;   // Q0
    } outer_t;

    // True when an address falls inside the outer register window.
    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return a[WIN_MSB:WIN_LSB] == WIN_TAG;
    endfunction
endpackage

// File: rtl/mc_outer_reg.sv
// Outer value register with write qualification.
// Assumes cpu_we is a one-cycle strobe and the status bits are valid with it.
module mc_outer_reg
    import mc_outer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic              wram_en,
    input  logic              wram_wp,
    output outer_t            q,
    output logic              win_hit
);
    logic wr_ok;

    // Decode the window and qualify the write with the status bits.
    always_comb begin
        win_hit = in_window(cpu_addr);
        wr_ok   = cpu_we && win_hit && wram_en && !wram_wp;
    end

    // Hold the outer value; load the low data bits on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_ok) begin
            q <= outer_t'(cpu_wdata[Q_W-1:0]);
        end
    end
endmodule

// File: rtl/mc_prg_xlat.sv
// Program bank translator: {Q2, A16, raw[2:0]}, A16 gated from Q and raw bit 3.
// Assumes RAW_W >= 3; a narrower raw bus treats the missing bit 3 as 0.
module mc_prg_xlat
    import mc_outer_pkg::*;
#(
    parameter int RAW_W = 6,
    parameter int OUT_W = 5
) (
    input  outer_t           q,
    input  logic [RAW_W-1:0] raw,
    output logic [OUT_W-1:0] bank
);
    localparam int KEEP = OUT_W - 2;
    logic m16;
    logic a16;

    // Pick raw bit KEEP when the raw bus is wide enough.
    generate
        if (RAW_W > KEEP) begin : g_m16
            assign m16 = raw[KEEP];
        end else begin : g_no_m16
            assign m16 = 1'b0;
        end
    endgenerate

    // Form the two outer-controlled address bits and the final bank.
    always_comb begin
        a16  = (q.mid & q.lo) | (q.hi & m16);
        bank = {q.hi, a16, raw[KEEP-1:0]};
    end
endmodule

// File: rtl/mc_chr_xlat.sv
// Character bank translator: Q2 placed above the low raw bits.
// Assumes OUT_W - 1 <= RAW_W.
module mc_chr_xlat
    import mc_outer_pkg::*;
#(
    parameter int RAW_W = 8,
    parameter int OUT_W = 8
) (
    input  outer_t           q,
    input  logic [RAW_W-1:0] raw,
    output logic [OUT_W-1:0] bank
);
    localparam int KEEP = OUT_W - 1;

    // Replace the top bit with the outer half select.
    always_comb begin
        bank = {q.hi, raw[KEEP-1:0]};
    end
endmodule

// File: rtl/mc_outer_xlat.sv
// Top: outer bank translator for a three-game cartridge.
// Assumes the inner controller supplies raw banks and work-RAM status bits.
module mc_outer_xlat
    import mc_outer_pkg::*;
#(
    parameter int RAW_PRG_W = 6,
    parameter int RAW_CHR_W = 8,
    parameter int PRG_OUT_W = 5,
    parameter int CHR_OUT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 cpu_we,
    input  logic                 cpu_rd,
    input  logic                 wram_en,
    input  logic                 wram_wp,
    input  logic [RAW_PRG_W-1:0] raw_prg,
    input  logic [RAW_CHR_W-1:0] raw_chr,
    output logic [PRG_OUT_W-1:0] prg_bank,
    output logic [CHR_OUT_W-1:0] chr_bank,
    output logic                 rd_own,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 inner_we
);
    outer_t outer_q;
    logic   win_hit;

    mc_outer_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_we   (cpu_we),
        .wram_en  (wram_en),
        .wram_wp  (wram_wp),
        .q        (outer_q),
        .win_hit  (win_hit)
    );

    mc_prg_xlat #(.RAW_W(RAW_PRG_W), .OUT_W(PRG_OUT_W)) u_prg (
        .q   (outer_q),
        .raw (raw_prg),
        .bank(prg_bank)
    );

    mc_chr_xlat #(.RAW_W(RAW_CHR_W), .OUT_W(CHR_OUT_W)) u_chr (
        .q   (outer_q),
        .raw (raw_chr),
        .bank(chr_bank)
    );

    // Claim window reads with zero data; keep window writes from the inner side.
    always_comb begin
        rd_own   = cpu_rd && win_hit;
        rd_data  = '0;
        inner_we = cpu_we && !win_hit;
    end
endmodule

// File: rtl/mc_outer_xlat_chk.sv
// Checker for the outer bank translator, bound to the top module.
module mc_outer_xlat_chk
    import mc_outer_pkg::*;
#(
    parameter int PRG_OUT_W = 5,
    parameter int CHR_OUT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic [DATA_W-1:0]    cpu_wdata,
    input logic                 cpu_we,
    input logic                 wram_en,
    input logic                 wram_wp,
    input logic [PRG_OUT_W-1:0] prg_bank,
    input logic [CHR_OUT_W-1:0] chr_bank,
    input logic                 rd_own,
    input logic [DATA_W-1:0]    rd_data,
    input outer_t               outer_q
);
    logic hit;
    assign hit = cpu_addr[15:13] == 3'b011;

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && hit && wram_en && !wram_wp) |=> chr_bank[CHR_OUT_W-1] == $past(cpu_wdata[2])); // R1
    AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && hit && (!wram_en || wram_wp)) |=> $stable(outer_q)); // R2
    AST_OUTSIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !hit) |=> $stable(outer_q)); // R7
    AST_PRG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        prg_bank[PRG_OUT_W-1] == chr_bank[CHR_OUT_W-1]); // R4
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_own |-> rd_data == '0); // R6
endmodule

bind mc_outer_xlat mc_outer_xlat_chk #(.PRG_OUT_W(PRG_OUT_W), .CHR_OUT_W(CHR_OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_we   (cpu_we),
    .wram_en  (wram_en),
    .wram_wp  (wram_wp),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .rd_own   (rd_own),
    .rd_data  (rd_data),
    .outer_q  (outer_q)
);

// File: tb/tb_mc_outer_xlat.sv
module tb_mc_outer_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h8000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_we = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        wram_en = 1'b1;
    logic        wram_wp = 1'b0;
    logic [5:0]  raw_prg = 6'h0F;
    logic [7:0]  raw_chr = 8'h05;
    logic [4:0]  prg_bank;
    logic [7:0]  chr_bank;
    logic        rd_own;
    logic [7:0]  rd_data;
    logic        inner_we;

    int checks = 0;
    int errors = 0;
    int mq = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    mc_outer_xlat dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rd(cpu_rd), .wram_en(wram_en), .wram_wp(wram_wp),
        .raw_prg(raw_prg), .raw_chr(raw_chr), .prg_bank(prg_bank), .chr_bank(chr_bank),
        .rd_own(rd_own), .rd_data(rd_data), .inner_we(inner_we)
    );

    function automatic int in_win(input int a);
        return (a >= 24576 && a <= 32767) ? 1 : 0;
    endfunction
    function automatic int exp_prg(input int q, input int raw);
        int a16;
        a16 = (((q / 2) % 2) & (q % 2)) | ((q / 4) & ((raw / 8) % 2));
        return (q / 4) * 16 + a16 * 8 + raw % 8;
    endfunction
    function automatic int exp_chr(input int q, input int raw);
        return (q / 4) * 128 + raw % 128;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model of the outer value, advanced on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) mq = 0;
        else if (cpu_we && in_win(int'(cpu_addr)) == 1 && wram_en && !wram_wp)
            mq = int'(cpu_wdata) % 8;
    end

    // Compare every output against the model on every clock.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R4", int'(prg_bank), exp_prg(mq, int'(raw_prg)));
            chk("R5", int'(chr_bank), exp_chr(mq, int'(raw_chr)));
            chk("R6", int'(rd_own), (cpu_rd && in_win(int'(cpu_addr)) == 1) ? 1 : 0);
            if (rd_own) chk("R6", int'(rd_data), 0);
            chk("R7", int'(inner_we), (cpu_we && in_win(int'(cpu_addr)) == 0) ? 1 : 0);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        step();
        cpu_we = 1'b0; cpu_addr = 16'h8000;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        chk("R3", int'(prg_bank), 7);
        chk("R3", int'(chr_bank), 5);
        rst_n = 1'b1;
        step();
        cmp_on = 1'b1;
        // R8 corner values
        #1 chk("R8", int'(prg_bank), 7);
        step();
        wr(16'h6000, 8'h03);
        #1 chk("R8", int'(prg_bank), 15);
        chk("R8", int'(chr_bank), 5);
        wr(16'h7FFF, 8'hFC);   // R1: upper data bits dropped, Q=4
        #1 chk("R8", int'(prg_bank), 31);
        chk("R8", int'(chr_bank), 133);
        // R2: each rejected status combination
        wram_wp = 1'b1; wr(16'h6000, 8'h00);
        #1 chk("R2", int'(prg_bank), 31);
        wram_en = 1'b0; wram_wp = 1'b0; wr(16'h6123, 8'h03);
        #1 chk("R2", int'(prg_bank), 31);
        wram_wp = 1'b1; wr(16'h7000, 8'h00);
        #1 chk("R2", int'(chr_bank), 133);
        wram_en = 1'b1; wram_wp = 1'b0;
        // R7: writes just outside the window
        wr(16'h5FFF, 8'h00);
        #1 chk("R7", int'(prg_bank), 31);
        wr(16'h8000, 8'h03);
        #1 chk("R7", int'(prg_bank), 31);
        // R6: reads at edges and outside
        cpu_rd = 1'b1; cpu_addr = 16'h6000; step();
        #1 chk("R6", int'(rd_own), 1);
        cpu_addr = 16'h7FFF; step();
        cpu_addr = 16'h5FFF; step();
        #1 chk("R6", int'(rd_own), 0);
        cpu_rd = 1'b0; cpu_addr = 16'h8000;
        // R9 with R4/R5 sweep: new raw values each cycle, checked same cycle
        for (int q = 0; q < 8; q++) begin
            wr(16'h6000, 8'(q + 8 * q));
            for (int r = 0; r < 256; r++) begin
                raw_prg = 6'(r % 64);
                raw_chr = 8'(r);
                #1 chk("R9", int'(prg_bank), exp_prg(q, r % 64));
                step();
            end
        end
        // Reset again: R3
        wr(16'h6000, 8'h07);
        rst_n = 1'b0; cmp_on = 1'b0; raw_prg = 6'h0F; step();
        #1 chk("R3", int'(prg_bank), 7);
        rst_n = 1'b1; cmp_on = 1'b1; step(); step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule